// File: doc/BRIEF.md
# Periodic Trigger Primitive Packetizer

This block gathers per-event classification results and hands them downstream as one packet per fixed time window. Each input primitive carries a 32-bit event timestamp, counted in 25 ns ticks of the common 40 MHz time base, and a 2-bit ring-count class. The class codes are 0, 1, 2, or 3 for three or more rings. A local time counter begins at zero on a start-of-burst pulse. It cuts time into windows of 256 ticks (6.4 µs), and a primitive belongs to the window given by its timestamp shifted right by eight.

A packet is sent for every window, even when the window holds no primitives. The downstream aligner can then count delays in whole packets. Window w is sent only after `LATE_WIN` further windows have passed, so primitives may arrive that much late. Accepted primitives wait in a FIFO, and a small ring of per-window counters keeps the count each header needs. A primitive whose window has already been sent is dropped, and so is one that would exceed `MAX_PRIM` in its window. Both cases are counted in a sticky, saturating drop counter.

The control state machine has three states:

- S_IDLE waits until the oldest unsent window is due.
- S_HEAD presents the header beat. It moves to S_BODY when the header is accepted and the count is nonzero. It returns to S_IDLE when the header is accepted and the count is zero.
- S_BODY presents one primitive per beat and returns to S_IDLE when the last beat is accepted.

A start-of-burst pulse forces S_IDLE from any state.

Top module: `tp_packetizer`

## Requirements
- R1: After reset, `pkt_valid` is 0, `prim_ready` is 0 and `drop_count` is 0. No packet is produced and no primitive is accepted until the first start-of-burst pulse.
- R2: The time counter reads 0 in the cycle after the clock edge that samples `sob`, and it advances by one every cycle. Window w covers counter values w*256 to w*256+255. With the output never stalled, the header of window w is valid in the cycle where the counter equals (w+LATE_WIN+1)*256+1.
- R3: Exactly one packet is emitted per window, in window order starting from 0. This includes windows with no primitives.
- R4: The header is the first beat of each packet. `pkt_data[23:0]` holds the window number, `pkt_data[31:24]` holds the number of primitives that follow, and `pkt_data[33:32]` is 0.
- R5: Each body beat carries one primitive, with the class in `pkt_data[33:32]` and the timestamp in `pkt_data[31:0]`. Body beats appear in arrival order, and every one belongs to the window named in the header.
- R6: `pkt_last` is high only on the final beat of a packet. An empty packet is a single header beat with `pkt_last` high.
- R7: A primitive for window w that is accepted while the counter is below (w+LATE_WIN+1)*256 appears in window w's packet, even if it arrives during a later window.
- R8: A primitive accepted while the counter is at or above (w+LATE_WIN+1)*256 is discarded and adds one to `drop_count`.
- R9: At most `MAX_PRIM` primitives go into one window. Further ones for that window are discarded and each adds one to `drop_count`.
- R10: `drop_count` never decreases, saturates at its maximum, and is cleared only by reset, not by start-of-burst.
- R11: While `pkt_valid` is high and `pkt_ready` is low, the next cycle keeps `pkt_valid` high and `pkt_data` unchanged.
- R12: A start-of-burst pulse restarts the counter and window numbering at 0 and discards buffered primitives and window counts. The next packet is window 0.
- R13: `prim_ready` is low in the cycle a packet starts. With the output idle, that is the cycle where the counter equals (w+LATE_WIN+1)*256. `prim_ready` is also low while the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sob | input | 1 | Start-of-burst pulse, restarts the time counter |
| prim_valid | input | 1 | Primitive offered |
| prim_ready | output | 1 | Primitive taken on this edge if valid |
| prim_ts | input | 32 | Event timestamp in 25 ns ticks |
| prim_cls | input | 2 | Ring-count class (0, 1, 2, 3 or more) |
| pkt_valid | output | 1 | Packet beat valid |
| pkt_ready | input | 1 | Downstream accepts the beat |
| pkt_data | output | 34 | Header or primitive beat |
| pkt_last | output | 1 | Final beat of the packet |
| drop_count | output | 16 | Sticky saturating count of discarded primitives |

## Verification
The assertions assume the following about the inputs. Accepted primitives that are still in time arrive with nondecreasing timestamps. No timestamp lies ahead of the current window. `sob` never pulses while a packet is in flight. The oldest unsent window stays within the counter ring, meaning the output is never stalled for whole windows.

The stimulus keeps to these assumptions:
- Every timestamp is chosen at or below the counter value at which it is driven.
- Late and stale primitives are sent only after their in-time neighbours.
- The restart pulse is placed in a gap between packets.
- Output backpressure toggles beat by beat but never holds off a packet for long.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_BODY = 2'd2
    } pk_state_e;
endpackage

// File: rtl/tp_timebase.sv
module tp_timebase #(
    parameter int TS_W      = 32,
    parameter int TICK_LOG2 = 8,
    localparam int WIN_W    = TS_W - TICK_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sob,
    output logic             running,
    output logic [WIN_W-1:0] cur_win
);
    logic [TS_W-1:0] now_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            now_q   <= '0;
        end else if (sob) begin
            running <= 1'b1;
            now_q   <= '0;
        end else if (running) begin
            now_q   <= now_q + 1'b1;
        end
    end

    assign cur_win = now_q[TS_W-1:TICK_LOG2];

    // R2: the window index only ever holds or steps by one while running
    p_win_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running && !sob |=> (cur_win == $past(cur_win)) || (cur_win == $past(cur_win) + 1'b1));
endmodule

// File: rtl/tp_fifo.sv
module tp_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign rdata = mem[rp];

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        push && !flush |-> !full);
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !flush |-> !empty);
endmodule

// File: rtl/tp_packetizer.sv
module tp_packetizer #(
    parameter int TS_W       = 32,
    parameter int TICK_LOG2  = 8,
    parameter int LATE_WIN   = 1,
    parameter int MAX_PRIM   = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int DROP_W     = 16,
    localparam int WIN_W     = TS_W - TICK_LOG2,
    localparam int HCNT_W    = 8,
    localparam int DATA_W    = TS_W + 2,
    localparam int PAD_W     = DATA_W - HCNT_W - WIN_W,
    localparam int SLOT_W    = $clog2(LATE_WIN + 2),
    localparam int NSLOT     = 1 << SLOT_W,
    localparam int CNT_W     = $clog2(MAX_PRIM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sob,
    input  logic              prim_valid,
    output logic              prim_ready,
    input  logic [TS_W-1:0]   prim_ts,
    input  logic [1:0]        prim_cls,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [DATA_W-1:0] pkt_data,
    output logic              pkt_last,
    output logic [DROP_W-1:0] drop_count
);
    import tp_pkg::*;

    pk_state_e state, nstate;

    logic              running;
    logic [WIN_W-1:0]  cur_win;
    logic [WIN_W-1:0]  next_emit;
    logic [WIN_W-1:0]  hdr_win;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  win_cnt [NSLOT];
    logic [WIN_W-1:0]  in_win;
    logic [SLOT_W-1:0] in_slot, emit_slot;
    logic              due, start_pkt, accept, is_stale, is_over, push, pop;
    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic [DROP_W-1:0] drop_q;
    logic [TS_W-1:0]   last_push_ts;
    logic              have_push;

    tp_timebase #(.TS_W(TS_W), .TICK_LOG2(TICK_LOG2)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .sob     (sob),
        .running (running),
        .cur_win (cur_win)
    );

    tp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (sob),
        .push  (push),
        .wdata ({prim_cls, prim_ts}),
        .pop   (pop),
        .rdata (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // window bookkeeping
    assign in_win    = prim_ts[TS_W-1:TICK_LOG2];
    assign in_slot   = in_win[SLOT_W-1:0];
    assign emit_slot = next_emit[SLOT_W-1:0];
    assign due       = running && (cur_win >= next_emit + WIN_W'(LATE_WIN + 1));
    assign start_pkt = (state == S_IDLE) && due;
    assign prim_ready = running && !fifo_full && !start_pkt;
    assign accept    = prim_valid && prim_ready;
    assign is_stale  = in_win < next_emit;
    assign is_over   = win_cnt[in_slot] == CNT_W'(MAX_PRIM);
    assign push      = accept && !is_stale && !is_over;
    assign pop       = (state == S_BODY) && pkt_ready;

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLOT; s++) begin
            if (!rst_n || sob)
                win_cnt[s] <= '0;
            else if (start_pkt && emit_slot == SLOT_W'(s))
                win_cnt[s] <= '0;
            else if (push && in_slot == SLOT_W'(s))
                win_cnt[s] <= win_cnt[s] + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || sob) state <= S_IDLE;
        else               state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: if (due) nstate = S_HEAD;
            S_HEAD: if (pkt_ready) nstate = (hdr_cnt == '0) ? S_IDLE : S_BODY;
            S_BODY: if (pkt_ready && left == CNT_W'(1)) nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // packet datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n || sob) begin
            next_emit <= '0;
            hdr_win   <= '0;
            hdr_cnt   <= '0;
            left      <= '0;
        end else begin
            if (start_pkt) begin
                hdr_win   <= next_emit;
                hdr_cnt   <= win_cnt[emit_slot];
                next_emit <= next_emit + 1'b1;
            end
            if (state == S_HEAD && pkt_ready) left <= hdr_cnt;
            else if (pop)                     left <= left - 1'b1;
        end
    end

    // outputs
    always_comb begin
        pkt_valid = 1'b0;
        pkt_last  = 1'b0;
        pkt_data  = '0;
        unique case (state)
            S_HEAD: begin
                pkt_valid = 1'b1;
                pkt_last  = (hdr_cnt == '0);
                pkt_data  = {{PAD_W{1'b0}}, HCNT_W'(hdr_cnt), hdr_win};
            end
            S_BODY: begin
                pkt_valid = 1'b1;
                pkt_last  = (left == CNT_W'(1));
                pkt_data  = fifo_head;
            end
            default: ;
        endcase
    end

    // sticky drop counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_q <= '0;
        else if (accept && (is_stale || is_over) && drop_q != {DROP_W{1'b1}})
            drop_q <= drop_q + 1'b1;
    end
    assign drop_count = drop_q;

    // input-order tracking for the ordering assumption
    always_ff @(posedge clk) begin
        if (!rst_n || sob) begin
            have_push    <= 1'b0;
            last_push_ts <= '0;
        end else if (push) begin
            have_push    <= 1'b1;
            last_push_ts <= prim_ts;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pkt_valid && !prim_ready);
    p_no_early_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HEAD) && ($past(state) == S_IDLE) |-> cur_win > hdr_win + WIN_W'(LATE_WIN));
    p_push_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push && have_push && !sob |-> prim_ts >= last_push_ts);
    p_body_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_BODY |-> fifo_head[TS_W-1:TICK_LOG2] == hdr_win);
    p_body_not_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_BODY |-> !fifo_empty);
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_HEAD |-> hdr_cnt <= CNT_W'(MAX_PRIM));
    p_drop_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> drop_count >= $past(drop_count));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready && !sob |=> pkt_valid && $stable(pkt_data));
endmodule

// File: tb/tb_tp_packetizer.sv
module tb_tp_packetizer;
    localparam int L    = 1;
    localparam int MAXP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sob = 1'b0;
    logic        prim_valid = 1'b0;
    logic        prim_ready;
    logic [31:0] prim_ts = '0;
    logic [1:0]  prim_cls = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [33:0] pkt_data;
    logic        pkt_last;
    logic [15:0] drop_count;

    tp_packetizer dut (
        .clk(clk), .rst_n(rst_n), .sob(sob),
        .prim_valid(prim_valid), .prim_ready(prim_ready),
        .prim_ts(prim_ts), .prim_cls(prim_cls),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data), .pkt_last(pkt_last),
        .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    int tb_now = 0;
    always @(posedge clk) begin
        if (sob) tb_now <= 0;
        else     tb_now <= tb_now + 1;
    end

    int          checks = 0, errors = 0;
    int          exp_cnt [64];
    logic [31:0] exp_ts  [64][MAXP];
    logic [1:0]  exp_cls [64][MAXP];
    int          exp_drops = 0;
    int          exp_win = 0;
    bit          bp = 1'b0;
    bit          in_body = 1'b0;
    int          cur_w = 0, idx = 0, cur_n = 0;
    bit          stalled = 1'b0;
    logic [33:0] stall_data;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 64; i++) exp_cnt[i] = 0;
        exp_win = 0;
        in_body = 1'b0;
    endtask

    task automatic wait_now(input int n);
        while (tb_now < n) @(negedge clk);
    endtask

    // driver: offers one primitive, predicts whether it is kept (R7) or dropped (R8, R9)
    task automatic send(input int ts, input int cls);
        int w;
        @(negedge clk);
        prim_valid = 1'b1;
        prim_ts    = 32'(ts);
        prim_cls   = 2'(cls);
        #1;
        while (!prim_ready) begin
            @(negedge clk);
            #1;
        end
        w = ts >> 8;
        if (tb_now >= (w + L + 1) * 256 || exp_cnt[w] == MAXP) begin
            exp_drops++;
        end else begin
            exp_ts[w][exp_cnt[w]]  = 32'(ts);
            exp_cls[w][exp_cnt[w]] = 2'(cls);
            exp_cnt[w]++;
        end
        @(posedge clk);
        @(negedge clk);
        prim_valid = 1'b0;
    endtask

    task automatic do_sob();
        @(negedge clk);
        sob = 1'b1;
        clear_model();
        @(negedge clk);
        sob = 1'b0;
    endtask

    // output backpressure
    initial begin
        forever begin
            @(negedge clk);
            pkt_ready = bp ? ~pkt_ready : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (stalled) begin
                chk(pkt_valid && pkt_data == stall_data, "R11", "held beat",
                    longint'(pkt_data), longint'(stall_data));
                stalled = 1'b0;
            end
            if (pkt_valid && !pkt_ready) begin
                stalled    = 1'b1;
                stall_data = pkt_data;
            end
            if (pkt_valid && pkt_ready) begin
                if (!in_body) begin
                    cur_w = int'(pkt_data[23:0]);
                    cur_n = int'(pkt_data[31:24]);
                    chk(cur_w == exp_win, "R3", "header window", cur_w, exp_win);
                    chk(cur_n == exp_cnt[exp_win & 63], "R4", "header count", cur_n, exp_cnt[exp_win & 63]);
                    chk(pkt_data[33:32] == 2'b00, "R4", "header pad", pkt_data[33:32], 0);
                    chk(pkt_last == (cur_n == 0), "R6", "header last", pkt_last, (cur_n == 0));
                    if (!bp)
                        chk(tb_now == (cur_w + L + 1) * 256 + 1, "R2", "header cycle",
                            tb_now, (cur_w + L + 1) * 256 + 1);
                    if (cur_n > 0) begin
                        in_body = 1'b1;
                        idx = 0;
                    end else begin
                        exp_win++;
                    end
                end else begin
                    chk(pkt_data[31:0] == exp_ts[cur_w & 63][idx], "R5", "body timestamp",
                        pkt_data[31:0], exp_ts[cur_w & 63][idx]);
                    chk(pkt_data[33:32] == exp_cls[cur_w & 63][idx], "R5", "body class",
                        pkt_data[33:32], exp_cls[cur_w & 63][idx]);
                    chk(pkt_last == (idx == cur_n - 1), "R6", "body last", pkt_last, (idx == cur_n - 1));
                    idx++;
                    if (idx == cur_n) begin
                        in_body = 1'b0;
                        exp_win++;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", tb_now, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (4) @(negedge clk);
        chk(pkt_valid == 1'b0, "R1", "valid in reset", pkt_valid, 0);
        chk(prim_ready == 1'b0, "R1", "ready in reset", prim_ready, 0);
        chk(drop_count == 16'd0, "R10", "drop after reset", drop_count, 0);
        rst_n = 1'b1;
        prim_valid = 1'b1;
        repeat (20) @(negedge clk);
        chk(pkt_valid == 1'b0 && prim_ready == 1'b0, "R1", "quiet before burst",
            {pkt_valid, prim_ready}, 0);
        prim_valid = 1'b0;

        do_sob();
        wait_now(210);
        send(10, 0);
        send(20, 1);
        send(200, 3);
        wait_now(300);
        send(250, 2);                    // R7: late by one window, still kept
        wait_now(620);
        for (int i = 0; i < 9; i++) send(600 + i, i % 4);   // R9: ninth one over the limit
        send(100, 1);                    // R8: window 0 already sent
        wait_now(700);
        chk(drop_count == 16'(exp_drops), "R8", "drop count after stale", drop_count, exp_drops);
        chk(exp_drops == 2, "R9", "predicted drops", exp_drops, 2);
        wait_now(1024);
        chk(prim_ready == 1'b0, "R13", "ready at packet start", prim_ready, 0);
        @(negedge clk);
        chk(prim_ready == 1'b1, "R13", "ready after start", prim_ready, 1);

        wait_now(1300);
        send(1290, 1);
        send(1295, 2);
        wait_now(1400);
        bp = 1'b1;
        wait_now(1560);
        send(1550, 0);
        wait_now(1810);
        send(1800, 3);
        wait_now(2200);
        bp = 1'b0;
        wait_now(2290);
        chk(exp_win == 7, "R3", "packets in first burst", exp_win, 7);
        chk(pkt_valid == 1'b0, "R12", "gap before restart", pkt_valid, 0);

        do_sob();
        chk(drop_count == 16'd2, "R10", "drop kept over restart", drop_count, 2);
        wait_now(60);
        send(50, 2);
        wait_now(520);
        chk(exp_win == 1, "R12", "window 0 after restart", exp_win, 1);
        wait_now(1100);
        chk(exp_win == 3, "R3", "packets after restart", exp_win, 3);
        chk(drop_count == 16'd2, "R10", "drop final", drop_count, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule